// File: doc/BRIEF.md
# Transmitter Power Ramp Sequencer

This block produces the timed control strobes that bring a radio transmitter up before a frame and take it down afterwards. A one-cycle start request launches a fixed chain of phases: a short default-bit lead-in, a programmable header delay, a first gap, the window of the first data bit, a second gap, a wait for the data path to report the last bit, then a third gap, the window of the last data bit, a fourth gap, a programmable ramp-down delay and a fixed tail. When the chain returns to idle, the block raises a one-cycle completion flag.

Programmed delays are counted in bit-clock units, where one bit clock is twenty slow-clock ticks. The slow clock is either the input clock itself or an enable pulse that fires on every second input cycle, so the design stays on a single clock. Five internal timing strobes come out of the phase state. A mode bit routes them onto three control pins: command, amplifier enable and modulation. A fourth pin always carries the inverse of the command pin. The enable and modulation pins have selectable polarity. A software override can force all three pins, and polarity is applied after the override is selected.

Top module: `txramp_seq`

## Requirements
- R1: After reset, and whenever idle with override off, cmd_o=0, cmd_n_o=1, pe_o=pe_inv, mod_o=mod_inv and done_o=0.
- R2: With clk_gate=0 the phases last, in input cycles: lead-in 4, header 20*hdr_dly, each gap k 20*gapk_dly+2, each data-bit window 20, wait 1 when the last bit is already known, ramp-down 20*rdn_dly, tail 7. done_o rises T+1 edges after the edge that accepts start, where T is the sum of these phase lengths.
- R3: With map_sel=0 (all pins registered, one edge behind the phase), command is active from header to ramp-down, enable from gap1 to gap4, and modulation from the first-bit window to the last-bit window.
- R4: With map_sel=1, command is active for every non-idle phase (lead-in to tail), enable from gap2 to gap3, and modulation as in R3.
- R5: A phase whose programmed part and fixed part are both zero lasts exactly one slow tick.
- R6: With clk_gate=1 every slow tick takes 2 input cycles, so each phase is twice as long and done_o rises 2T+1 edges after the start edge.
- R7: The wait phase holds until last_bit is seen. A last_bit pulse during any earlier active phase is remembered, and the wait then lasts one slow tick. A last_bit that arrives during the wait ends it at that edge.
- R8: A start request while a sequence is active has no effect on its timing and does not cause a second completion.
- R9: done_o is high for exactly one cycle per sequence, in the first cycle in which the pins show the idle levels.
- R10: pe_o and mod_o are the selected levels XORed with pe_inv and mod_inv (1 = inverted). cmd_n_o is always the inverse of cmd_o.
- R11: With ovr_en=1, from the next edge each pin takes its override bit (then polarity). The sequencer keeps running unchanged, and done_o still arrives on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start a ramp sequence (accepted only when idle) |
| last_bit | input | 1 | Data path reports the last data bit |
| clk_gate | input | 1 | 0: slow tick every cycle; 1: slow tick every second cycle |
| map_sel | input | 1 | Selects the internal-to-pin strobe mapping |
| hdr_dly | input | DLY_W | Header delay in bit clocks |
| gap1_dly | input | DLY_W | Gap 1 in bit clocks |
| gap2_dly | input | DLY_W | Gap 2 in bit clocks |
| gap3_dly | input | DLY_W | Gap 3 in bit clocks |
| gap4_dly | input | DLY_W | Gap 4 in bit clocks |
| rdn_dly | input | DLY_W | Ramp-down delay in bit clocks |
| pe_inv | input | 1 | Invert the amplifier-enable pin |
| mod_inv | input | 1 | Invert the modulation pin |
| ovr_en | input | 1 | Drive the pins from the override bits |
| ovr_cmd | input | 1 | Override level for command |
| ovr_pe | input | 1 | Override level for amplifier enable |
| ovr_mod | input | 1 | Override level for modulation |
| cmd_o | output | 1 | Command pin |
| cmd_n_o | output | 1 | Inverse of the command pin |
| pe_o | output | 1 | Amplifier-enable pin |
| mod_o | output | 1 | Modulation pin |
| done_o | output | 1 | One-cycle sequence completion pulse |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a fresh start request and a phase advance of a running sequence: the bench pulses start in the middle of a sequence and requires the completion time and the single done pulse to stay unchanged. The second pair is the override and the sequencer, which both feed the pins: the override is held for a whole sequence and the bench requires constant forced pin levels, with polarity applied, while done_o still lands on the cycle the timing formula predicts. The bench also delivers last_bit both before and during the wait phase and compares the completion times.

// File: rtl/txramp_pkg.sv
package txramp_pkg;

    localparam int BIT_DIV_DEF   = 20;
    localparam int GAP_XTRA_DEF  = 2;
    localparam int LEAD_DEF      = 4;
    localparam int TAIL_DEF      = 7;
    localparam int GATE_DIV_DEF  = 2;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LEAD,
        PH_HDR,
        PH_GAP1,
        PH_FIRST,
        PH_GAP2,
        PH_WAIT,
        PH_GAP3,
        PH_LAST,
        PH_GAP4,
        PH_RDN,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic cmd;
        logic pe;
        logic modu;
        logic pon;
        logic dtx;
    } tsig_t;

    typedef struct packed {
        logic cmd;
        logic pe;
        logic modu;
    } pins_t;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_LEAD:  return PH_HDR;
            PH_HDR:   return PH_GAP1;
            PH_GAP1:  return PH_FIRST;
            PH_FIRST: return PH_GAP2;
            PH_GAP2:  return PH_WAIT;
            PH_WAIT:  return PH_GAP3;
            PH_GAP3:  return PH_LAST;
            PH_LAST:  return PH_GAP4;
            PH_GAP4:  return PH_RDN;
            PH_RDN:   return PH_TAIL;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic tsig_t phase_strobes(phase_e p);
        tsig_t s;
        s.pon  = (p != PH_IDLE);
        s.cmd  = p inside {PH_HDR, PH_GAP1, PH_FIRST, PH_GAP2, PH_WAIT,
                           PH_GAP3, PH_LAST, PH_GAP4, PH_RDN};
        s.pe   = p inside {PH_GAP1, PH_FIRST, PH_GAP2, PH_WAIT,
                           PH_GAP3, PH_LAST, PH_GAP4};
        s.modu = p inside {PH_FIRST, PH_GAP2, PH_WAIT, PH_GAP3, PH_LAST};
        s.dtx  = p inside {PH_GAP2, PH_WAIT, PH_GAP3};
        return s;
    endfunction

endpackage

// File: rtl/txramp_tick.sv
module txramp_tick #(
    parameter int GATE_DIV = txramp_pkg::GATE_DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    input  logic run,
    output logic slow_en
);
    localparam int DW = (GATE_DIV > 1) ? $clog2(GATE_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(GATE_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign slow_en = gate ? (div_q == DIV_LAST) : 1'b1;

    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (gate && run && slow_en) |=> (!slow_en || !gate));

endmodule

// File: rtl/txramp_fsm.sv
module txramp_fsm
    import txramp_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int BIT_DIV  = BIT_DIV_DEF,
    parameter int GAP_XTRA = GAP_XTRA_DEF,
    parameter int LEAD_LEN = LEAD_DEF,
    parameter int TAIL_LEN = TAIL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_en,
    input  logic             start_req,
    input  logic             last_bit,
    input  logic [DLY_W-1:0] hdr_dly,
    input  logic [DLY_W-1:0] gap1_dly,
    input  logic [DLY_W-1:0] gap2_dly,
    input  logic [DLY_W-1:0] gap3_dly,
    input  logic [DLY_W-1:0] gap4_dly,
    input  logic [DLY_W-1:0] rdn_dly,
    output phase_e           phase_o,
    output logic             seq_done_o
);
    localparam int MAX_V  = (1 << DLY_W) - 1;
    localparam int MAX_T  = MAX_V * BIT_DIV + GAP_XTRA + LEAD_LEN + TAIL_LEN + BIT_DIV;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] K_BIT  = CNT_W'(BIT_DIV);
    localparam logic [CNT_W-1:0] K_GAP  = CNT_W'(GAP_XTRA);
    localparam logic [CNT_W-1:0] K_LEAD = CNT_W'(LEAD_LEN);
    localparam logic [CNT_W-1:0] K_TAIL = CNT_W'(TAIL_LEN);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W-1:0]  span;
    logic              span_end;
    logic              last_seen_q;
    logic              done_q;

    function automatic logic [CNT_W-1:0] scaled(logic [DLY_W-1:0] v,
                                                logic [CNT_W-1:0] fixed);
        return CNT_W'(v) * K_BIT + fixed;
    endfunction

    always_comb begin
        case (phase_q)
            PH_LEAD:  span = K_LEAD;
            PH_HDR:   span = scaled(hdr_dly, '0);
            PH_GAP1:  span = scaled(gap1_dly, K_GAP);
            PH_FIRST: span = K_BIT;
            PH_GAP2:  span = scaled(gap2_dly, K_GAP);
            PH_GAP3:  span = scaled(gap3_dly, K_GAP);
            PH_LAST:  span = K_BIT;
            PH_GAP4:  span = scaled(gap4_dly, K_GAP);
            PH_RDN:   span = scaled(rdn_dly, '0);
            PH_TAIL:  span = K_TAIL;
            default:  span = '0;
        endcase
    end

    assign cnt_nx   = cnt_q + 1'b1;
    assign span_end = (span == '0) || (cnt_nx >= span);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            last_seen_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (phase_q != PH_IDLE && last_bit) begin
                last_seen_q <= 1'b1;
            end
            case (phase_q)
                PH_IDLE: begin
                    last_seen_q <= 1'b0;
                    cnt_q       <= '0;
                    if (start_req) begin
                        phase_q <= PH_LEAD;
                    end
                end
                PH_WAIT: begin
                    if (slow_en && (last_seen_q || last_bit)) begin
                        phase_q <= PH_GAP3;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (slow_en) begin
                        if (span_end) begin
                            phase_q <= next_phase(phase_q);
                            cnt_q   <= '0;
                            if (phase_q == PH_TAIL) begin
                                done_q <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_nx;
                        end
                    end
                end
            endcase
        end
    end

    assign phase_o    = phase_q;
    assign seq_done_o = done_q;

    p_hold_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT && !last_seen_q && !last_bit) |=> (phase_q == PH_WAIT));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_LEAD) |=> (phase_q != PH_LEAD));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_count_in_span_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_WAIT && span != '0) |-> (cnt_q < span));

    p_tick_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (!slow_en && phase_q != PH_IDLE) |=> $stable(phase_q));

endmodule

// File: rtl/txramp_map.sv
module txramp_map
    import txramp_pkg::*;
(
    input  phase_e phase,
    input  logic   map_sel,
    output pins_t  seq_pins
);
    tsig_t s;

    always_comb begin
        s = phase_strobes(phase);
        if (map_sel) begin
            seq_pins.cmd  = s.pon;
            seq_pins.pe   = s.dtx;
            seq_pins.modu = s.modu;
        end else begin
            seq_pins.cmd  = s.cmd;
            seq_pins.pe   = s.pe;
            seq_pins.modu = s.modu;
        end
    end

endmodule

// File: rtl/txramp_pins.sv
module txramp_pins
    import txramp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t seq_pins,
    input  logic  ovr_en,
    input  pins_t ovr_pins,
    input  logic  pe_inv,
    input  logic  mod_inv,
    input  logic  seq_done,
    output logic  cmd_o,
    output logic  cmd_n_o,
    output logic  pe_o,
    output logic  mod_o,
    output logic  done_o
);
    pins_t sel;
    logic  cmd_q, cmd_n_q, pe_q, mod_q, done_q;

    assign sel = ovr_en ? ovr_pins : seq_pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= 1'b0;
            cmd_n_q <= 1'b1;
            pe_q    <= 1'b0;
            mod_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            cmd_q   <= sel.cmd;
            cmd_n_q <= ~sel.cmd;
            pe_q    <= sel.pe ^ pe_inv;
            mod_q   <= sel.modu ^ mod_inv;
            done_q  <= seq_done;
        end
    end

    assign cmd_o   = cmd_q;
    assign cmd_n_o = cmd_n_q;
    assign pe_o    = pe_q;
    assign mod_o   = mod_q;
    assign done_o  = done_q;

    p_ovr_follow_r11: assert property (@(posedge clk) disable iff (rst)
        ovr_en |=> (cmd_o == $past(ovr_pins.cmd)) &&
                   (pe_o == ($past(ovr_pins.pe) ^ $past(pe_inv))) &&
                   (mod_o == ($past(ovr_pins.modu) ^ $past(mod_inv))));

    p_cmd_pair_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_n_o == !cmd_o);

endmodule

// File: rtl/txramp_seq.sv
module txramp_seq
    import txramp_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int BIT_DIV  = BIT_DIV_DEF,
    parameter int GAP_XTRA = GAP_XTRA_DEF,
    parameter int LEAD_LEN = LEAD_DEF,
    parameter int TAIL_LEN = TAIL_DEF,
    parameter int GATE_DIV = GATE_DIV_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             last_bit,
    input  logic             clk_gate,
    input  logic             map_sel,
    input  logic [DLY_W-1:0] hdr_dly,
    input  logic [DLY_W-1:0] gap1_dly,
    input  logic [DLY_W-1:0] gap2_dly,
    input  logic [DLY_W-1:0] gap3_dly,
    input  logic [DLY_W-1:0] gap4_dly,
    input  logic [DLY_W-1:0] rdn_dly,
    input  logic             pe_inv,
    input  logic             mod_inv,
    input  logic             ovr_en,
    input  logic             ovr_cmd,
    input  logic             ovr_pe,
    input  logic             ovr_mod,
    output logic             cmd_o,
    output logic             cmd_n_o,
    output logic             pe_o,
    output logic             mod_o,
    output logic             done_o
);
    phase_e phase;
    logic   slow_en;
    logic   seq_done;
    pins_t  seq_pins;
    pins_t  ovr_pins;

    assign ovr_pins = '{cmd: ovr_cmd, pe: ovr_pe, modu: ovr_mod};

    txramp_tick #(.GATE_DIV(GATE_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .gate    (clk_gate),
        .run     (phase != PH_IDLE),
        .slow_en (slow_en)
    );

    txramp_fsm #(
        .DLY_W    (DLY_W),
        .BIT_DIV  (BIT_DIV),
        .GAP_XTRA (GAP_XTRA),
        .LEAD_LEN (LEAD_LEN),
        .TAIL_LEN (TAIL_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .slow_en    (slow_en),
        .start_req  (start_req),
        .last_bit   (last_bit),
        .hdr_dly    (hdr_dly),
        .gap1_dly   (gap1_dly),
        .gap2_dly   (gap2_dly),
        .gap3_dly   (gap3_dly),
        .gap4_dly   (gap4_dly),
        .rdn_dly    (rdn_dly),
        .phase_o    (phase),
        .seq_done_o (seq_done)
    );

    txramp_map u_map (
        .phase    (phase),
        .map_sel  (map_sel),
        .seq_pins (seq_pins)
    );

    txramp_pins u_pins (
        .clk      (clk),
        .rst      (rst),
        .seq_pins (seq_pins),
        .ovr_en   (ovr_en),
        .ovr_pins (ovr_pins),
        .pe_inv   (pe_inv),
        .mod_inv  (mod_inv),
        .seq_done (seq_done),
        .cmd_o    (cmd_o),
        .cmd_n_o  (cmd_n_o),
        .pe_o     (pe_o),
        .mod_o    (mod_o),
        .done_o   (done_o)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !ovr_en) |=> !cmd_o);

    p_done_at_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !$past(ovr_en)) |-> !cmd_o);

endmodule

// File: tb/txramp_seq_tb.sv
`timescale 1ns/1ps
module txramp_seq_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, last_bit = 1'b0, clk_gate = 1'b0, map_sel = 1'b0;
    logic [7:0] hd = '0, g1 = '0, g2 = '0, g3 = '0, g4 = '0, rd = '0;
    logic pe_inv = 1'b0, mod_inv = 1'b0;
    logic ovr_en = 1'b0, ovr_cmd = 1'b0, ovr_pe = 1'b0, ovr_mod = 1'b0;
    logic cmd_o, cmd_n_o, pe_o, mod_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    // results of the last run
    int nd, w_cmd, w_pe, w_mod, n_done, n_pair_bad, idle_bad, cmd_at_done;

    always #4 clk = ~clk;

    txramp_seq u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .last_bit(last_bit),
        .clk_gate(clk_gate), .map_sel(map_sel),
        .hdr_dly(hd), .gap1_dly(g1), .gap2_dly(g2), .gap3_dly(g3),
        .gap4_dly(g4), .rdn_dly(rd),
        .pe_inv(pe_inv), .mod_inv(mod_inv),
        .ovr_en(ovr_en), .ovr_cmd(ovr_cmd), .ovr_pe(ovr_pe), .ovr_mod(ovr_mod),
        .cmd_o(cmd_o), .cmd_n_o(cmd_n_o), .pe_o(pe_o), .mod_o(mod_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ph(input int v, input int fixed);
        return (v * 20 + fixed == 0) ? 1 : v * 20 + fixed;
    endfunction

    // phase lengths in slow ticks
    function automatic int p_hdr();  return ph(int'(hd), 0); endfunction
    function automatic int p_g1();   return ph(int'(g1), 2); endfunction
    function automatic int p_g2();   return ph(int'(g2), 2); endfunction
    function automatic int p_g3();   return ph(int'(g3), 2); endfunction
    function automatic int p_g4();   return ph(int'(g4), 2); endfunction
    function automatic int p_rd();   return ph(int'(rd), 0); endfunction
    function automatic int up_to_wait(); return 4 + p_hdr() + p_g1() + 20 + p_g2(); endfunction
    function automatic int after_wait(); return p_g3() + 20 + p_g4() + p_rd() + 7; endfunction
    function automatic int total();      return up_to_wait() + 1 + after_wait(); endfunction
    function automatic int w_cmd0();     return total() - 4 - 7; endfunction
    function automatic int w_pe0();      return p_g1() + 20 + p_g2() + 1 + p_g3() + 20 + p_g4(); endfunction
    function automatic int w_modx();     return 20 + p_g2() + 1 + p_g3() + 20; endfunction
    function automatic int w_pe1();      return p_g2() + 1 + p_g3(); endfunction

    // lmode: 0 last_bit held high, 1 pulse at lpos; spos: extra start pulse
    task automatic run_seq(input int lmode, input int lpos, input int spos);
        int n;
        nd = -1; w_cmd = 0; w_pe = 0; w_mod = 0; n_done = 0;
        n_pair_bad = 0; idle_bad = 0; cmd_at_done = -1;
        @(negedge clk);
        start_req = 1'b1;
        last_bit  = (lmode == 0);
        n = 0;
        while (nd < 0 && n < 20000) begin
            @(negedge clk);
            n++;
            start_req = (n == spos);
            if (lmode != 0) last_bit = (n == lpos);
            if (cmd_o) w_cmd++;
            if (pe_o ^ pe_inv) w_pe++;
            if (mod_o ^ mod_inv) w_mod++;
            if (cmd_n_o != !cmd_o) n_pair_bad++;
            if (done_o) begin
                nd = n;
                n_done++;
                cmd_at_done = int'(cmd_o);
            end
        end
        start_req = 1'b0;
        last_bit  = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done_o) n_done++;
            if (!ovr_en && (cmd_o || !cmd_n_o || pe_o != pe_inv || mod_o != mod_inv))
                idle_bad++;
        end
    endtask

    task automatic t_reset();
        check(cmd_o == 1'b0 && cmd_n_o == 1'b1, "R1 reset cmd pair", {cmd_o, cmd_n_o}, 1);
        check(pe_o == 1'b0 && mod_o == 1'b0, "R1 reset pe/mod", {pe_o, mod_o}, 0);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
    endtask

    task automatic t_basic();
        clk_gate = 0; map_sel = 0; pe_inv = 0; mod_inv = 0;
        hd = 2; g1 = 1; g2 = 0; g3 = 3; g4 = 1; rd = 1;
        run_seq(0, 0, 0);
        check(nd == total() + 2, "R2 done latency", nd, total() + 2);
        check(w_cmd == w_cmd0(), "R3 cmd width", w_cmd, w_cmd0());
        check(w_pe == w_pe0(), "R3 pe width", w_pe, w_pe0());
        check(w_mod == w_modx(), "R3 mod width", w_mod, w_modx());
        check(n_done == 1, "R9 single done", n_done, 1);
        check(cmd_at_done == 0, "R9 done with idle pins", cmd_at_done, 0);
        check(n_pair_bad == 0, "R10 cmd_n inverse", n_pair_bad, 0);
        check(idle_bad == 0, "R1 idle after run", idle_bad, 0);
    endtask

    task automatic t_mode1_inv();
        clk_gate = 0; map_sel = 1; pe_inv = 1; mod_inv = 1;
        hd = 1; g1 = 2; g2 = 1; g3 = 0; g4 = 2; rd = 3;
        @(negedge clk); @(negedge clk);
        check(pe_o == 1'b1 && mod_o == 1'b1, "R10 idle inverted levels", {pe_o, mod_o}, 3);
        run_seq(0, 0, 0);
        check(w_cmd == total(), "R4 cmd spans sequence", w_cmd, total());
        check(w_pe == w_pe1(), "R4 pe gap2..gap3", w_pe, w_pe1());
        check(w_mod == w_modx(), "R4 mod width", w_mod, w_modx());
        check(cmd_at_done == 0, "R9 done with idle pins", cmd_at_done, 0);
        check(idle_bad == 0, "R1 idle after inverted run", idle_bad, 0);
        map_sel = 0; pe_inv = 0; mod_inv = 0;
    endtask

    task automatic t_zero();
        clk_gate = 0; hd = 0; g1 = 0; g2 = 0; g3 = 0; g4 = 0; rd = 0;
        run_seq(0, 0, 0);
        check(nd == 64, "R5 zero delays latency", nd, 64);
        check(w_cmd == w_cmd0(), "R5 zero cmd width", w_cmd, w_cmd0());
    endtask

    task automatic t_gate();
        clk_gate = 1; map_sel = 0;
        hd = 1; g1 = 0; g2 = 1; g3 = 0; g4 = 1; rd = 2;
        run_seq(0, 0, 0);
        check(nd == 2 * total() + 2, "R6 gated latency", nd, 2 * total() + 2);
        check(w_pe == 2 * w_pe0(), "R6 gated pe width", w_pe, 2 * w_pe0());
        check(n_done == 1, "R6 gated single done", n_done, 1);
        clk_gate = 0;
    endtask

    task automatic t_last();
        clk_gate = 0; hd = 0; g1 = 0; g2 = 0; g3 = 0; g4 = 0; rd = 0;
        run_seq(1, 40, 0);
        check(nd == 40 + after_wait() + 2, "R7 late last_bit", nd, 40 + after_wait() + 2);
        run_seq(1, 10, 0);
        check(nd == total() + 2, "R7 early last_bit remembered", nd, total() + 2);
    endtask

    task automatic t_busy_start();
        clk_gate = 0; hd = 2; g1 = 1; g2 = 0; g3 = 3; g4 = 1; rd = 1;
        run_seq(0, 0, 50);
        check(nd == total() + 2, "R8 start while busy latency", nd, total() + 2);
        check(n_done == 1, "R8 no second completion", n_done, 1);
    endtask

    task automatic t_override();
        clk_gate = 0; map_sel = 0; pe_inv = 1; mod_inv = 0;
        hd = 1; g1 = 1; g2 = 1; g3 = 1; g4 = 1; rd = 1;
        ovr_en = 1; ovr_cmd = 1; ovr_pe = 0; ovr_mod = 1;
        @(negedge clk); @(negedge clk);
        check(cmd_o == 1 && pe_o == 1 && mod_o == 1, "R11 forced idle pins",
              {cmd_o, pe_o, mod_o}, 7);
        run_seq(0, 0, 0);
        check(nd == total() + 2, "R11 timing under override", nd, total() + 2);
        check(w_cmd == nd && w_mod == nd, "R11 cmd/mod forced", w_cmd + w_mod, 2 * nd);
        check(w_pe == 0, "R11 pe forced off", w_pe, 0);
        ovr_en = 0;
        @(negedge clk); @(negedge clk);
        check(cmd_o == 0 && cmd_n_o == 1 && pe_o == 1, "R1 idle after override",
              {cmd_o, cmd_n_o, pe_o}, 3);
        pe_inv = 0;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mode1_inv();
        t_zero();
        t_gate();
        t_last();
        t_busy_start();
        t_override();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule